// File: doc/BRIEF.md
# Ternary-Match Multicast Spike Router

This block is one routing node in a mesh of spike-processing chips. Spike packets carry a 32-bit source key. A packet arrives on one of six inter-chip links (two horizontal, two vertical, two diagonal) or from the local cores. The node looks up the key in a table of ternary entries. Each entry holds a value word, a care mask and a valid bit. A hit yields a fan-out vector of 24 bits. That vector selects any mix of the 18 local cores and the six outgoing links, and the packet is copied to every destination it selects.

When no entry matches, a packet that came in on a link leaves on the link on the far side of the node, so that it keeps its direction of travel. A locally injected packet that misses has nowhere sensible to go. It is discarded and a sticky error flag is set. The seven sources share the lookup through a round-robin arbiter. A packet stays at its input until every destination it selects has taken it. Software or a boot controller fills the table through a synchronous write port.

Top module: `spike_mcast_router`

## Requirements
- R1: After reset all output valids, all input readies and miss_err are low, and every table entry is invalid, so the first keys all miss.
- R2: A valid entry matches a key when (key XOR value) AND care is zero: a care bit of 1 compares that position, and a care bit of 0 is don't-care.
- R3: When several valid entries match, the lowest-numbered one supplies the route, and an invalid entry never matches.
- R4: A hit copies the packet to every destination whose bit is set in the fan-out vector: bits 0 to 17 drive core_out_valid[0..17] and bits 18 to 23 drive link_out_valid[0..5].
- R5: A packet from link i that misses leaves only on link (i+3) mod 6.
- R6: A local packet that misses is accepted at its input, goes to no output, and sets miss_err, which stays high until reset.
- R7: The packet stays at its input (ready low) until every selected destination has accepted it. Each destination receives it exactly once, and out_key carries its key.
- R8: An output valid that is not accepted stays high in the next cycle.
- R9: Sources are numbered 0 to 5 for the links and 6 for the local input. After source s is served, the search for the next grant starts at s+1 mod 7.
- R10: A table write takes effect for any lookup in the cycle after the write edge.
- R11: At most one input is accepted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry written |
| tbl_valid | input | 1 | Valid bit written |
| tbl_value | input | KEY_W | Value word written |
| tbl_care | input | KEY_W | Care mask written (1 = compare) |
| tbl_route | input | CORES+6 | Fan-out vector written |
| link_in_valid | input | 6 | Link input valids |
| link_in_key | input | 6*KEY_W | Link input keys, link i at bits i*KEY_W upward |
| link_in_ready | output | 6 | Link input accepted |
| loc_in_valid | input | 1 | Local input valid |
| loc_in_key | input | KEY_W | Local input key |
| loc_in_ready | output | 1 | Local input accepted |
| core_out_valid | output | CORES | Per-core delivery valid |
| core_out_ready | input | CORES | Per-core delivery ready |
| link_out_valid | output | 6 | Per-link delivery valid |
| link_out_ready | input | 6 | Per-link delivery ready |
| out_key | output | KEY_W | Key of the packet being delivered |
| miss_err | output | 1 | Sticky local-miss flag |

## Verification
A corrupted fan-out register or a lost pending bit shows at the ports the cycle after the grant. It appears as an extra or missing valid, or as an input released before all of its destinations took the packet. A wrong round-robin pointer shows at the next pop, because the source that is released differs from the expected one. A stale or wrongly prioritised table entry changes the destination set of the very next packet that uses that key.

// File: rtl/spike_rt_pkg.sv
// Shared constants for the spike router: link count, source numbering.
// Assumes six links; source LOCAL_SRC is the local injection port.
package spike_rt_pkg;
    localparam int LINKS     = 6;
    localparam int SOURCES   = LINKS + 1;
    localparam int LOCAL_SRC = LINKS;
    localparam int SRC_W     = $clog2(SOURCES);
endpackage

// File: rtl/route_tcam.sv
// Ternary route table: DEPTH entries of value, care mask, valid and fan-out.
// Combinational lookup with lowest-index priority; synchronous single write.
// Assumes DEPTH >= 2. Only the valid bits are reset.
module route_tcam #(
    parameter int KEY_W   = 32,
    parameter int DEPTH   = 1024,
    parameter int ROUTE_W = 24,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_care,
    input  logic [ROUTE_W-1:0] wr_route,
    input  logic [KEY_W-1:0]   lk_key,
    output logic               lk_hit,
    output logic [ROUTE_W-1:0] lk_route
);
    logic [DEPTH-1:0]   ent_vld;
    logic [KEY_W-1:0]   ent_val [DEPTH];
    logic [KEY_W-1:0]   ent_care[DEPTH];
    logic [ROUTE_W-1:0] ent_rte [DEPTH];
    logic [DEPTH-1:0]   ent_match;
    logic [IDX_W-1:0]   win_idx;

    // Valid bits: cleared at reset, written by the port.
    always_ff @(posedge clk) begin
        if (!rst_n)     ent_vld <= '0;
        else if (wr_en) ent_vld[wr_idx] <= wr_valid;
    end

    // Entry payload storage, no reset needed behind the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_val[wr_idx]  <= wr_value;
            ent_care[wr_idx] <= wr_care;
            ent_rte[wr_idx]  <= wr_route;
        end
    end

    // One ternary comparator per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign ent_match[g] = ent_vld[g] &&
                              (((lk_key ^ ent_val[g]) & ent_care[g]) == '0);
    end

    // Priority pick: scanning downward leaves the lowest matching index.
    always_comb begin
        lk_hit  = 1'b0;
        win_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_match[i]) begin
                lk_hit  = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    // Fan-out read for the winning entry.
    assign lk_route = ent_rte[win_idx];
endmodule

// File: rtl/rr_arbiter.sv
// Round-robin arbiter over N requesters. The search starts at the
// pointer; the pointer moves past a source when the caller reports it served.
// Assumes adv_idx < N.
module rr_arbiter #(
    parameter int N      = 7,
    localparam int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    input  logic [IW-1:0] adv_idx,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q;

    // Rotating search for the first request at or after the pointer.
    always_comb begin
        int cand;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N; off++) begin
            cand = int'(ptr_q) + off;
            if (cand >= N) cand = cand - N;
            if (!gnt_any && req[cand]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'(cand);
            end
        end
    end

    // Pointer moves to the source after the one just served.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (adv) ptr_q <= (int'(adv_idx) == N - 1) ? '0 : adv_idx + 1'b1;
    end

    // R9
    gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_idx]);
    // R9
    head_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr_q] |-> (gnt_any && gnt_idx == ptr_q));
endmodule

// File: rtl/spike_mcast_router.sv
// Multicast spike router node. Arbitrates seven sources, looks up the key
// in a ternary table, and delivers one packet at a time to every selected
// core/link with per-destination valid/ready. Misses from a link go to
// the opposite link; local misses are dropped and flagged.
// Assumes one packet in flight; a grant cycle precedes delivery.
module spike_mcast_router
    import spike_rt_pkg::*;
#(
    parameter int KEY_W   = 32,
    parameter int DEPTH   = 1024,
    parameter int CORES   = 18,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ROUTE_W = CORES + 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_idx,
    input  logic                 tbl_valid,
    input  logic [KEY_W-1:0]     tbl_value,
    input  logic [KEY_W-1:0]     tbl_care,
    input  logic [ROUTE_W-1:0]   tbl_route,
    input  logic [5:0]           link_in_valid,
    input  logic [6*KEY_W-1:0]   link_in_key,
    output logic [5:0]           link_in_ready,
    input  logic                 loc_in_valid,
    input  logic [KEY_W-1:0]     loc_in_key,
    output logic                 loc_in_ready,
    output logic [CORES-1:0]     core_out_valid,
    input  logic [CORES-1:0]     core_out_ready,
    output logic [5:0]           link_out_valid,
    input  logic [5:0]           link_out_ready,
    output logic [KEY_W-1:0]     out_key,
    output logic                 miss_err
);
    logic [SOURCES-1:0] src_valid;
    logic [SOURCES-1:0] src_ready;
    logic [SOURCES-1:0] arb_req;
    logic [KEY_W-1:0]   src_key [SOURCES];
    logic [ROUTE_W-1:0] straight[SOURCES];
    logic               gnt_any;
    logic [SRC_W-1:0]   gnt_idx;
    logic [KEY_W-1:0]   sel_key;
    logic               tc_hit;
    logic [ROUTE_W-1:0] tc_route;
    logic [ROUTE_W-1:0] dest;
    logic               busy_q;
    logic [SRC_W-1:0]   cur_src_q;
    logic [KEY_W-1:0]   key_q;
    logic [ROUTE_W-1:0] pend_q;
    logic               err_q;
    logic [ROUTE_W-1:0] out_rdy;
    logic [ROUTE_W-1:0] rem;
    logic               fin;
    logic               drop;
    logic               take;
    logic               adv;
    logic [SRC_W-1:0]   adv_idx;

    // Gather link keys and the fixed miss routes per link.
    for (genvar i = 0; i < LINKS; i++) begin : g_src
        assign src_key[i]  = link_in_key[i*KEY_W +: KEY_W];
        assign straight[i] = ROUTE_W'(1) << (CORES + ((i + 3) % LINKS));
    end
    assign src_key[LOCAL_SRC]  = loc_in_key;
    assign straight[LOCAL_SRC] = '0;
    assign src_valid = {loc_in_valid, link_in_valid};

    // Arbitration is offered only while no packet is in flight.
    assign arb_req = busy_q ? '0 : src_valid;

    rr_arbiter #(.N(SOURCES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (arb_req),
        .adv     (adv),
        .adv_idx (adv_idx),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    assign sel_key = src_key[gnt_idx];

    route_tcam #(.KEY_W(KEY_W), .DEPTH(DEPTH), .ROUTE_W(ROUTE_W)) u_tcam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_valid (tbl_valid),
        .wr_value (tbl_value),
        .wr_care  (tbl_care),
        .wr_route (tbl_route),
        .lk_key   (sel_key),
        .lk_hit   (tc_hit),
        .lk_route (tc_route)
    );

    // Destination set: table route on a hit, straight-through on a miss.
    assign dest = tc_hit ? tc_route : straight[gnt_idx];

    // Grant outcome: local misses are dropped, all else goes in flight.
    assign drop = !busy_q && gnt_any && !tc_hit && (int'(gnt_idx) == LOCAL_SRC);
    assign take = !busy_q && gnt_any && !drop;

    // Delivery progress: destinations still waiting after this cycle.
    assign out_rdy = {link_out_ready, core_out_ready};
    assign rem     = pend_q & ~out_rdy;
    assign fin     = busy_q && (rem == '0);

    // Arbiter bookkeeping: advance past whichever source is released.
    assign adv     = fin || drop;
    assign adv_idx = busy_q ? cur_src_q : gnt_idx;

    // Input release: at the end of delivery, or at once for a drop.
    always_comb begin
        for (int i = 0; i < SOURCES; i++) begin
            src_ready[i] = (fin && cur_src_q == SRC_W'(i)) ||
                           (drop && gnt_idx == SRC_W'(i));
        end
    end
    assign link_in_ready = src_ready[LINKS-1:0];
    assign loc_in_ready  = src_ready[LOCAL_SRC];

    // Packet-in-flight state: capture on grant, clear bits as accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cur_src_q <= '0;
            key_q     <= '0;
            pend_q    <= '0;
        end else if (busy_q) begin
            pend_q <= rem;
            if (rem == '0) busy_q <= 1'b0;
        end else if (take) begin
            busy_q    <= 1'b1;
            cur_src_q <= gnt_idx;
            key_q     <= sel_key;
            pend_q    <= dest;
        end
    end

    // Sticky miss flag for dropped local packets.
    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (drop) err_q <= 1'b1;
    end

    assign core_out_valid = busy_q ? pend_q[CORES-1:0] : '0;
    assign link_out_valid = busy_q ? pend_q[ROUTE_W-1:CORES] : '0;
    assign out_key        = key_q;
    assign miss_err       = err_q;

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |=> miss_err);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|({link_out_valid, core_out_valid} & ~out_rdy)) |=>
        (($past({link_out_valid, core_out_valid} & ~out_rdy) &
          ~{link_out_valid, core_out_valid}) == '0));
    // R7
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fin) |=> ($stable(out_key) && busy_q));
    // R11
    one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_in_ready, link_in_ready}));
endmodule

// File: tb/sim_spike_mcast_router.sv
`timescale 1ns/1ps
module sim_spike_mcast_router;
    localparam int KW = 32;
    localparam int DP = 16;
    localparam int NC = 18;
    localparam int RW = NC + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          tbl_we = 1'b0;
    logic [3:0]    tbl_idx = '0;
    logic          tbl_valid = 1'b0;
    logic [KW-1:0] tbl_value = '0, tbl_care = '0;
    logic [RW-1:0] tbl_route = '0;
    logic [6:0]    drv_valid = '0;
    logic [KW-1:0] drv_key [7];
    logic [6*KW-1:0] link_key_bus;
    logic [5:0]    link_in_ready, link_out_valid;
    logic [5:0]    link_out_ready = '1;
    logic          loc_in_ready, miss_err;
    logic [NC-1:0] core_out_valid;
    logic [NC-1:0] core_out_ready = '1;
    logic [KW-1:0] out_key;

    for (genvar i = 0; i < 6; i++) begin : g_k
        assign link_key_bus[i*KW +: KW] = drv_key[i];
    end

    spike_mcast_router #(.KEY_W(KW), .DEPTH(DP), .CORES(NC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_value(tbl_value), .tbl_care(tbl_care), .tbl_route(tbl_route),
        .link_in_valid(drv_valid[5:0]), .link_in_key(link_key_bus),
        .link_in_ready(link_in_ready),
        .loc_in_valid(drv_valid[6]), .loc_in_key(drv_key[6]),
        .loc_in_ready(loc_in_ready),
        .core_out_valid(core_out_valid), .core_out_ready(core_out_ready),
        .link_out_valid(link_out_valid), .link_out_ready(link_out_ready),
        .out_key(out_key), .miss_err(miss_err)
    );

    // Behavioural reference table and per-source expectations.
    logic [KW-1:0] m_val [DP];
    logic [KW-1:0] m_care[DP];
    logic [RW-1:0] m_rte [DP];
    bit            m_vld [DP];
    logic [RW-1:0] exp_m [7];
    logic [RW-1:0] got = '0;
    logic [KW-1:0] seen_key = '0;
    logic [6:0]    popped = '0;
    logic [RW-1:0] prev_wait = '0;
    int rr_next = 0;
    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [RW-1:0] ref_route(input logic [KW-1:0] k, input int s);
        for (int i = 0; i < DP; i++)
            if (m_vld[i] && (((k ^ m_val[i]) & m_care[i]) == '0)) return m_rte[i];
        if (s < 6) return RW'(1) << (NC + ((s + 3) % 6));
        return '0;
    endfunction

    task automatic wr(input int idx, input bit v, input logic [KW-1:0] val,
                      input logic [KW-1:0] care, input logic [RW-1:0] rt);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_valid = v;
        tbl_value = val; tbl_care = care; tbl_route = rt;
        m_vld[idx] = v; m_val[idx] = val; m_care[idx] = care; m_rte[idx] = rt;
        @(posedge clk); #1;
        tbl_we = 1'b0;
    endtask

    task automatic send(input int s, input logic [KW-1:0] k);
        exp_m[s] = ref_route(k, s);
        drv_key[s] = k;
        drv_valid[s] = 1'b1;
        do begin @(posedge clk); #1; end while (drv_valid[s]);
    endtask

    // Release inputs after the edge on which they were accepted.
    always begin
        @(posedge clk); #1;
        for (int i = 0; i < 7; i++)
            if (popped[i]) begin drv_valid[i] = 1'b0; popped[i] = 1'b0; end
    end

    // Cycle-by-cycle comparison against the reference expectations.
    always @(negedge clk) begin
        logic [RW-1:0] hs;
        logic [RW-1:0] vnow;
        logic [6:0]    pops;
        int s, want;
        if (rst_n) begin
            vnow = {link_out_valid, core_out_valid};
            hs   = vnow & {link_out_ready, core_out_ready};
            pops = {loc_in_ready, link_in_ready} & drv_valid;
            if (prev_wait != '0)
                chk((prev_wait & ~vnow) == '0, "R8", "held valid", 64'(vnow), 64'(prev_wait));
            prev_wait = vnow & ~{link_out_ready, core_out_ready};
            if ((hs & got) != '0)
                chk(1'b0, "R7", "duplicate delivery", 64'(hs), 64'(got & ~hs));
            if (hs != '0 && got == '0) seen_key = out_key;
            got = got | hs;
            if (pops != '0) begin
                chk($onehot0(pops), "R11", "single pop", 64'(pops), 64'(0));
                s = 0;
                for (int i = 0; i < 7; i++) if (pops[i]) s = i;
                want = -1;
                for (int off = 0; off < 7; off++)
                    if (want < 0 && drv_valid[(rr_next + off) % 7]) want = (rr_next + off) % 7;
                chk(s == want, "R9", "served source", 64'(s), 64'(want));
                chk(got == exp_m[s], "R4 R5 R7", "delivered set", 64'(got), 64'(exp_m[s]));
                if (got != '0)
                    chk(seen_key == drv_key[s], "R7", "out_key", 64'(seen_key), 64'(drv_key[s]));
                rr_next = (s + 1) % 7;
                got = '0;
                popped[s] = 1'b1;
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) begin drv_key[i] = '0; exp_m[i] = '0; end
        for (int i = 0; i < DP; i++) begin m_vld[i] = 0; m_val[i] = '0; m_care[i] = '0; m_rte[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk({core_out_valid, link_out_valid} == '0, "R1", "outputs in reset", 64'({core_out_valid, link_out_valid}), 64'(0));
        chk({loc_in_ready, link_in_ready, miss_err} == '0, "R1", "readies/err in reset", 64'({loc_in_ready, link_in_ready, miss_err}), 64'(0));
        @(posedge clk); #1; rst_n = 1'b1;
        // R1: empty table -> link 2 misses, exits link 5
        send(2, 32'hA5A5_1234);
        // R2 R4: don't-care low half, fan-out core0, core17, link1
        wr(3, 1, 32'hA5A5_0000, 32'hFFFF_0000, 24'h0A_0001);
        send(0, 32'hA5A5_1234);
        // R3: exact entry 1 beats entry 3
        wr(1, 1, 32'hA5A5_1234, 32'hFFFF_FFFF, 24'h00_0020);
        send(0, 32'hA5A5_1234);
        // R3 R10: invalidate entry 1, very next lookup uses entry 3
        wr(1, 0, 32'hA5A5_1234, 32'hFFFF_FFFF, 24'h00_0020);
        send(4, 32'hA5A5_1234);
        // R2: a compared bit differs -> miss
        send(1, 32'hA5A4_1234);
        // R5: every link straight through
        for (int i = 0; i < 6; i++) send(i, 32'h0000_00FF);
        // R6: local miss dropped and flagged, sticky afterwards
        send(6, 32'h0000_0001);
        @(negedge clk);
        chk(miss_err == 1'b1, "R6", "miss_err set", 64'(miss_err), 64'(1));
        send(6, 32'hA5A5_9999);
        @(negedge clk);
        chk(miss_err == 1'b1, "R6", "miss_err sticky", 64'(miss_err), 64'(1));
        // R7 R8: link 5 stalls, input held until it accepts
        wr(5, 1, 32'h5555_0000, 32'hFFFF_0000, 24'h80_0001);
        @(posedge clk); #1; link_out_ready[5] = 1'b0;
        fork send(6, 32'h5555_0042); join_none
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(loc_in_ready == 1'b0, "R7", "input held", 64'(loc_in_ready), 64'(0));
        chk(link_out_valid[5] == 1'b1 && core_out_valid[0] == 1'b0, "R7", "only stalled dest waits",
            64'({link_out_valid, core_out_valid}), 64'(24'h80_0000));
        @(posedge clk); #1; link_out_ready[5] = 1'b1;
        while (drv_valid[6]) begin @(posedge clk); #1; end
        // R9: all seven sources at once
        fork
            send(0, 32'h0000_0100); send(1, 32'h0000_0101); send(2, 32'h0000_0102);
            send(3, 32'h0000_0103); send(4, 32'h0000_0104); send(5, 32'h0000_0105);
            send(6, 32'hA5A5_0007);
        join
        // R4: hit with an empty fan-out releases the input with no delivery
        wr(7, 1, 32'h7777_7777, 32'hFFFF_FFFF, 24'h00_0000);
        send(3, 32'h7777_7777);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule